// File: doc/BRIEF.md
# Line-Coalescing Masked Vector Gather Sequencer

This block carries out a masked gather of eight 32-bit elements. It takes a base address, one signed 32-bit index per lane, a power-of-two scale, a mask vector and the previous destination vector. The lane mask is the sign bit of each 32-bit element of the mask vector.

While lanes remain pending, the sequencer picks the lowest-numbered pending lane and works out which 64-byte line that lane reads. Every other pending lane that reads the same line joins it in one line request. The request carries the line index, a bitmap of the lanes it serves and the byte offset of each lane within its line. When the line comes back, the served lanes take their words from it and leave the working mask.

The result starts as the old destination vector, so lanes with a clear mask bit keep their old value. An abort ends the gather early. It reports the lanes that are still unfinished and keeps the data already loaded. Address translation and the cache are outside the block: a request handshake and a line-return strobe connect it to memory.

Top module: `line_gather_seq`

## Requirements
- R1: The lane mask for lane i is bit 32*i+31 of `mask_vec`. The other bits of `mask_vec` have no effect.
- R2: The address of lane i is `base_addr` plus the sign-extended index of lane i (bits 32*i+31..32*i of `index_vec`) shifted left by `scale_log2` (0..3, meaning x1, x2, x4, x8). Its line index is address[63:6] and its byte offset is address[5:0]. The base, indices, scale, mask and old destination are captured in the cycle `start` is accepted.
- R3: Each request is led by the lowest-numbered pending lane. `req_line` is the leader's line index, and `req_lanes` holds exactly the pending lanes whose line index equals it.
- R4: `req_offs` bits 6*i+5..6*i hold the byte offset of lane i.
- R5: `req_valid` stays high with `req_line` and `req_lanes` unchanged until `req_ready` is seen, unless an abort occurs. After a handshake, no further request is raised until `rsp_valid` has been received.
- R6: On `rsp_valid`, each served lane i takes result bits 32*i+31..32*i from `rsp_data` bits starting at 8*offset, little-endian. Bytes beyond the end of the line read as zero. The served lanes are then cleared from the working mask.
- R7: A lane whose mask bit is clear holds its `old_dst` value in `result`.
- R8: When all active lanes fall in one line, the whole gather makes exactly one request. In general, it makes one request per distinct line.
- R9: An all-zero lane mask raises `done` in the cycle after `start`, with no request, `result` equal to `old_dst` and `mask_out` zero.
- R10: `done` is a one-cycle pulse in the cycle after the final line return. On normal completion `mask_out` is zero, and `result` and `mask_out` stay valid until the next `start`.
- R11: `abort` while busy raises `done` in the next cycle, and `mask_out` then holds exactly the unfinished lanes. No request is accepted in the abort cycle. A line returning in the abort cycle is still merged. Loaded lanes keep their data, and unloaded lanes keep the old destination value.
- R12: `start` while busy and `abort` while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a gather (accepted when idle) |
| base_addr | input | 64 | Base byte address |
| index_vec | input | 256 | Eight signed 32-bit lane indices |
| scale_log2 | input | 2 | Index shift: 0..3 for x1..x8 |
| mask_vec | input | 256 | Mask vector; the sign bit of each lane is used |
| old_dst | input | 256 | Previous destination vector |
| abort | input | 1 | Stop the gather now |
| busy | output | 1 | Gather in progress |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_line | output | 58 | Line index (address bits 63..6) |
| req_lanes | output | 8 | Lanes served by this request |
| req_offs | output | 48 | Byte offset in the line, 6 bits per lane |
| rsp_valid | input | 1 | Line data returned |
| rsp_data | input | 512 | Returned 64-byte line, byte 0 in the low bits |
| done | output | 1 | One-cycle completion pulse |
| result | output | 256 | Blended destination vector |
| mask_out | output | 8 | Remaining lanes (zero if complete) |

## Verification
A line return and an abort can land in the same cycle. The bench provokes this by raising `abort` together with `rsp_valid` for the first line of a two-line gather. It then expects that line's lanes to be merged into `result` and dropped from `mask_out`, while the second line's lanes stay set. A second overlap is a stray `start` during a running gather. The bench drives one with a different mask and judges it by the final result and mask, which must match the first gather alone.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } lgc_state_e;

   localparam int SCALE_W = 2;
endpackage

// File: rtl/lgc_lane_addr.sv
module lgc_lane_addr #(
   parameter int LANES  = 8,
   parameter int ELEM_W = 32,
   parameter int ADDR_W = 64,
   parameter int OFS_W  = 6,
   localparam int LIDX_W = ADDR_W - OFS_W
) (
   input  logic [ADDR_W-1:0]       base,
   input  logic [LANES*ELEM_W-1:0] idx,
   input  logic [1:0]              scale,
   output logic [LANES*LIDX_W-1:0] lines,
   output logic [LANES*OFS_W-1:0]  offs
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [ELEM_W-1:0] ix;
      logic [ADDR_W-1:0] wide;
      logic [ADDR_W-1:0] addr;
      assign ix = idx[g*ELEM_W +: ELEM_W];
      if (ADDR_W > ELEM_W) begin : g_sext
         assign wide = {{(ADDR_W-ELEM_W){ix[ELEM_W-1]}}, ix};
      end else begin : g_trunc
         assign wide = ix[ADDR_W-1:0];
      end
      assign addr = base + (wide << scale);
      assign lines[g*LIDX_W +: LIDX_W] = addr[ADDR_W-1:OFS_W];
      assign offs[g*OFS_W +: OFS_W]    = addr[OFS_W-1:0];
   end
endmodule

// File: rtl/lgc_line_pick.sv
module lgc_line_pick #(
   parameter int LANES  = 8,
   parameter int LIDX_W = 58,
   localparam int LANE_IW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0]        pend,
   input  logic [LANES*LIDX_W-1:0] lines,
   output logic [LANES-1:0]        match,
   output logic [LIDX_W-1:0]       lead_line
);
   logic [LANE_IW-1:0] lead;

   // priority encoder: lowest pending lane leads
   always_comb begin
      lead = '0;
      for (int i = LANES-1; i >= 0; i--) begin
         if (pend[i]) lead = LANE_IW'(i);
      end
   end

   assign lead_line = lines[lead*LIDX_W +: LIDX_W];

   for (genvar g = 0; g < LANES; g++) begin : g_cmp
      assign match[g] = pend[g] && (lines[g*LIDX_W +: LIDX_W] == lead_line);
   end

   always_comb begin
      if (pend != '0) begin
         AST_MATCH_NONEMPTY: assert (match != '0); // R3
      end
   end
endmodule

// File: rtl/lgc_line_extract.sv
module lgc_line_extract #(
   parameter int LANES      = 8,
   parameter int ELEM_W     = 32,
   parameter int LINE_BYTES = 64,
   localparam int OFS_W  = $clog2(LINE_BYTES),
   localparam int LINE_W = LINE_BYTES * 8
) (
   input  logic [LINE_W-1:0]       data,
   input  logic [LANES*OFS_W-1:0]  offs,
   output logic [LANES*ELEM_W-1:0] words
);
   for (genvar g = 0; g < LANES; g++) begin : g_word
      logic [LINE_W-1:0] shifted;
      // logical shift: bytes past the line end come in as zero
      assign shifted = data >> {offs[g*OFS_W +: OFS_W], 3'b000};
      assign words[g*ELEM_W +: ELEM_W] = shifted[ELEM_W-1:0];
   end
endmodule

// File: rtl/line_gather_seq.sv
module line_gather_seq
   import lgc_pkg::*;
#(
   parameter int LANES      = 8,
   parameter int ELEM_W     = 32,
   parameter int ADDR_W     = 64,
   parameter int LINE_BYTES = 64,
   localparam int OFS_W  = $clog2(LINE_BYTES),
   localparam int LIDX_W = ADDR_W - OFS_W,
   localparam int LINE_W = LINE_BYTES * 8,
   localparam int VEC_W  = LANES * ELEM_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [ADDR_W-1:0]      base_addr,
   input  logic [VEC_W-1:0]       index_vec,
   input  logic [SCALE_W-1:0]     scale_log2,
   input  logic [VEC_W-1:0]       mask_vec,
   input  logic [VEC_W-1:0]       old_dst,
   input  logic                   abort,
   output logic                   busy,
   output logic                   req_valid,
   input  logic                   req_ready,
   output logic [LIDX_W-1:0]      req_line,
   output logic [LANES-1:0]       req_lanes,
   output logic [LANES*OFS_W-1:0] req_offs,
   input  logic                   rsp_valid,
   input  logic [LINE_W-1:0]      rsp_data,
   output logic                   done,
   output logic [VEC_W-1:0]       result,
   output logic [LANES-1:0]       mask_out
);
   // elaboration-time parameter checks
   if (LINE_BYTES != (1 << OFS_W)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if ((ELEM_W % 8) != 0 || ELEM_W > LINE_W) begin : g_bad_elem
      $error("ELEM_W must be whole bytes and fit in a line");
   end
   if (ADDR_W < ELEM_W || ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W too narrow");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least one");
   end

   lgc_state_e            state_q;
   logic [LANES-1:0]      mask_q, served_q;
   logic [ADDR_W-1:0]     base_q;
   logic [VEC_W-1:0]      idx_q, res_q, res_next, words;
   logic [SCALE_W-1:0]    scale_q;
   logic                  done_q;
   logic [LANES-1:0]      sign_mask, match, mask_next;
   logic [LANES*LIDX_W-1:0] lines;
   logic [LANES*OFS_W-1:0]  offs;
   logic [LIDX_W-1:0]     lead_line;
   logic                  hs, ret;
   logic                  mvec_unused;

   // phase one: lane mask from element sign bits
   for (genvar g = 0; g < LANES; g++) begin : g_sign
      assign sign_mask[g] = mask_vec[g*ELEM_W + ELEM_W - 1];
   end
   assign mvec_unused = ^mask_vec;

   lgc_lane_addr #(
      .LANES(LANES), .ELEM_W(ELEM_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
   ) u_addr (
      .base(base_q), .idx(idx_q), .scale(scale_q), .lines(lines), .offs(offs)
   );

   lgc_line_pick #(
      .LANES(LANES), .LIDX_W(LIDX_W)
   ) u_pick (
      .pend(mask_q), .lines(lines), .match(match), .lead_line(lead_line)
   );

   lgc_line_extract #(
      .LANES(LANES), .ELEM_W(ELEM_W), .LINE_BYTES(LINE_BYTES)
   ) u_ext (
      .data(rsp_data), .offs(offs), .words(words)
   );

   // phase three: blend returned words over the running result
   for (genvar g = 0; g < LANES; g++) begin : g_blend
      assign res_next[g*ELEM_W +: ELEM_W] =
         served_q[g] ? words[g*ELEM_W +: ELEM_W] : res_q[g*ELEM_W +: ELEM_W];
   end

   assign req_valid = (state_q == ST_ISSUE) && !abort;
   assign req_line  = lead_line;
   assign req_lanes = match;
   assign req_offs  = offs;
   assign hs        = req_valid && req_ready;
   assign ret       = (state_q == ST_WAIT) && rsp_valid;
   assign mask_next = mask_q & ~served_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         mask_q   <= '0;
         served_q <= '0;
         base_q   <= '0;
         idx_q    <= '0;
         scale_q  <= '0;
         res_q    <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  base_q  <= base_addr;
                  idx_q   <= index_vec;
                  scale_q <= scale_log2;
                  res_q   <= old_dst;
                  mask_q  <= sign_mask;
                  if (sign_mask == '0) done_q  <= 1'b1;
                  else                 state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (abort) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (hs) begin
                  served_q <= match;
                  state_q  <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (ret) begin
                  res_q  <= res_next;
                  mask_q <= mask_next;
                  if (abort || mask_next == '0) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_ISSUE;
                  end
               end else if (abort) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign result   = res_q;
   assign mask_out = mask_q;

   AST_REQ_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ((req_lanes & ~mask_q) == '0)); // R3
   AST_REQ_LEADER: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ((req_lanes & mask_q & (~mask_q + 1'b1)) != '0)); // R3
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=>
         (abort || (req_valid && $stable(req_line) && $stable(req_lanes)))); // R5
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_valid); // R5
   AST_MASK_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((mask_q & ~$past(mask_q)) == '0)); // R6
   AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(state_q == ST_WAIT) && !$past(abort)) |-> (mask_out == '0)); // R10
   AST_ABORT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && abort) |=> (done && !busy)); // R11
endmodule

// File: tb/line_gather_seq_tb_top.sv
module line_gather_seq_tb_top;
   typedef struct packed {
      logic [63:0]  base;
      logic [1:0]   sc;
      logic [7:0]   m;
      logic [255:0] idx;
      logic [7:0]   nreq;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{64'h1000, 2'd2, 8'hFF, {32'd7,32'd6,32'd5,32'd4,32'd3,32'd2,32'd1,32'd0}, 8'd1},
      '{64'h2000, 2'd3, 8'hFF, {32'd7,32'd6,32'd5,32'd4,32'd3,32'd2,32'd1,32'd0}, 8'd1},
      '{64'h3000, 2'd0, 8'hFF, {32'd448,32'd384,32'd320,32'd256,32'd192,32'd128,32'd64,32'd0}, 8'd8},
      '{64'h4000, 2'd2, 8'hA5, {32'd19,32'd3,32'd18,32'd2,32'd17,32'd1,32'd16,32'd0}, 8'd2},
      '{64'h5000, 2'd2, 8'h3C, {32'hFFFFFFF8,32'hFFFFFFF9,32'hFFFFFFFA,32'hFFFFFFFB,
                                32'hFFFFFFFC,32'hFFFFFFFD,32'hFFFFFFFE,32'hFFFFFFFF}, 8'd1},
      '{64'h603D, 2'd0, 8'h01, {8{32'd0}}, 8'd1},
      '{64'h7000, 2'd1, 8'hFF, {32'd140,32'd120,32'd100,32'd80,32'd60,32'd40,32'd20,32'd0}, 8'd5},
      '{64'h8000, 2'd2, 8'h00, {32'd7,32'd6,32'd5,32'd4,32'd3,32'd2,32'd1,32'd0}, 8'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [63:0]   base_addr = '0;
   logic [255:0]  index_vec = '0;
   logic [1:0]    scale_log2 = '0;
   logic [255:0]  mask_vec = '0;
   logic [255:0]  old_dst = '0;
   logic          abort = 1'b0;
   logic          busy;
   logic          req_valid;
   logic          req_ready = 1'b0;
   logic [57:0]   req_line;
   logic [7:0]    req_lanes;
   logic [47:0]   req_offs;
   logic          rsp_valid = 1'b0;
   logic [511:0]  rsp_data = '0;
   logic          done;
   logic [255:0]  result;
   logic [7:0]    mask_out;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #10ns clk = ~clk;

   line_gather_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .index_vec(index_vec), .scale_log2(scale_log2), .mask_vec(mask_vec),
      .old_dst(old_dst), .abort(abort), .busy(busy), .req_valid(req_valid),
      .req_ready(req_ready), .req_line(req_line), .req_lanes(req_lanes),
      .req_offs(req_offs), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .done(done), .result(result), .mask_out(mask_out)
   );

   task automatic check(input bit ok, input string rq, input logic [255:0] act,
                        input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic logic [7:0] mem_byte(input logic [63:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
   endfunction

   function automatic logic [63:0] lane_addr(input logic [63:0] b, input logic [31:0] ix,
                                             input logic [1:0] sc);
      return b + ({{32{ix[31]}}, ix} << sc);
   endfunction

   function automatic logic [511:0] line_data(input logic [57:0] ln);
      logic [511:0] d;
      for (int b = 0; b < 64; b++) d[8*b +: 8] = mem_byte({ln, 6'b0} + 64'(b));
      return d;
   endfunction

   function automatic logic [31:0] elem(input logic [63:0] a);
      logic [31:0] e;
      for (int k = 0; k < 4; k++)
         e[8*k +: 8] = (int'(a[5:0]) + k < 64) ? mem_byte(a + 64'(k)) : 8'h00;
      return e;
   endfunction

   // abort_kind: 0 none, 1 abort while a request waits, 2 abort with line return
   task automatic run(input vec_t v, input int abort_kind, input int abort_at, input bit stray);
      logic [7:0]   pend;
      logic [255:0] exp_res;
      logic [63:0]  addrs [8];
      int nreq = 0;
      bit fin = 1'b0;
      for (int i = 0; i < 8; i++) begin
         exp_res[32*i +: 32] = 32'hD000_0000 | 32'(i) | {v.base[15:0], 16'h0};
         addrs[i] = lane_addr(v.base, v.idx[32*i +: 32], v.sc);
      end
      @(negedge clk);
      start = 1'b1; base_addr = v.base; index_vec = v.idx; scale_log2 = v.sc;
      old_dst = exp_res;
      for (int i = 0; i < 8; i++) mask_vec[32*i +: 32] = {v.m[i], 31'h2345_6789 ^ 31'(i)};
      @(negedge clk);
      start = 1'b0; base_addr = ~v.base; index_vec = ~v.idx; mask_vec = '1; old_dst = '0;
      pend = v.m;
      if (pend == 8'h00) begin
         check(done == 1'b1, "R9 done after zero mask", 256'(done), 256'(1));
         check(req_valid == 1'b0, "R9 no request", 256'(req_valid), 256'(0));
         check(result == exp_res, "R9 result equals old (R1 sign bits only)", result, exp_res);
         check(mask_out == 8'h00, "R9 mask_out", 256'(mask_out), 256'(0));
         fin = 1'b1;
      end
      for (int it = 0; it < 20 && !fin; it++) begin
         logic [7:0]  mt;
         logic [57:0] ln;
         logic [47:0] eo;
         int lead = 0;
         for (int i = 7; i >= 0; i--) if (pend[i]) lead = i;
         ln = addrs[lead][63:6];
         for (int i = 0; i < 8; i++) begin
            mt[i] = pend[i] && (addrs[i][63:6] == ln);
            eo[6*i +: 6] = addrs[i][5:0];
         end
         check(req_valid == 1'b1, "R5 request raised", 256'(req_valid), 256'(1));
         check(req_line == ln, "R2 line index", 256'(req_line), 256'(ln));
         check(req_lanes == mt, "R3 lane bitmap", 256'(req_lanes), 256'(mt));
         check(req_offs == eo, "R4 lane offsets", 256'(req_offs), 256'(eo));
         nreq++;
         if (abort_kind == 1 && nreq == abort_at) begin
            abort = 1'b1; req_ready = 1'b1;
            @(negedge clk);
            abort = 1'b0; req_ready = 1'b0;
            check(done == 1'b1, "R11 done after abort", 256'(done), 256'(1));
            check(busy == 1'b0, "R11 idle after abort", 256'(busy), 256'(0));
            check(mask_out == pend, "R11 remaining lanes", 256'(mask_out), 256'(pend));
            check(result == exp_res, "R11 loaded data kept", result, exp_res);
            fin = 1'b1;
         end else begin
            if (nreq == 1) begin
               if (stray) begin
                  start = 1'b1; base_addr = 64'hDEAD_0000; mask_vec = '1;
               end
               @(negedge clk);
               start = 1'b0;
               check(req_valid == 1'b1 && req_line == ln && req_lanes == mt,
                     "R5 request held", 256'(req_lanes), 256'(mt));
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            check(req_valid == 1'b0, "R5 one outstanding", 256'(req_valid), 256'(0));
            @(negedge clk);
            check(req_valid == 1'b0, "R5 wait for line", 256'(req_valid), 256'(0));
            rsp_valid = 1'b1; rsp_data = line_data(ln);
            if (abort_kind == 2 && nreq == abort_at) abort = 1'b1;
            @(negedge clk);
            rsp_valid = 1'b0; rsp_data = '0;
            for (int i = 0; i < 8; i++) if (mt[i]) exp_res[32*i +: 32] = elem(addrs[i]);
            pend = pend & ~mt;
            if (pend == 8'h00 || abort) begin
               check(done == 1'b1, "R10 done after last line", 256'(done), 256'(1));
               check(result == exp_res, "R6 R7 blended result", result, exp_res);
               check(mask_out == pend, abort ? "R11 mask with merged line" : "R10 mask zero",
                     256'(mask_out), 256'(pend));
               abort = 1'b0;
               fin = 1'b1;
            end else begin
               check(done == 1'b0, "R10 no early done", 256'(done), 256'(0));
            end
         end
      end
      if (abort_kind == 0)
         check(nreq == int'(v.nreq), "R8 request count", 256'(nreq), 256'(v.nreq));
      @(negedge clk);
      check(done == 1'b0, "R10 done is a pulse", 256'(done), 256'(0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && req_valid == 1'b0 && done == 1'b0, "R10 reset state",
            256'({busy, req_valid, done}), 256'(0));
      rst_n = 1'b1;
      @(negedge clk);
      for (int n = 0; n < NV; n++) run(VECS[n], 0, 0, 1'b0);
      // abort while the third request waits
      run(VECS[2], 1, 3, 1'b0);
      // abort together with the first line return
      run(VECS[3], 2, 1, 1'b0);
      // stray start during a gather (R12)
      run(VECS[6], 0, 0, 1'b1);
      // abort while idle (R12)
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      check(done == 1'b0 && busy == 1'b0, "R12 abort ignored when idle",
            256'({done, busy}), 256'(0));
      run(VECS[5], 0, 0, 1'b0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog R5 actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule